// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns one character at a time into an asynchronous serial frame on a single transmit line. A character enters through a valid/ready handshake. The framer takes it only while the line is idle, so `in_ready` is low for the whole frame and acts as back-pressure. An upstream source holds `in_valid` and `in_data` steady until it sees `in_ready` high at a rising clock edge. A character offered while the framer is busy is neither taken nor queued.

An 8-bit line-control input sets the frame format. It chooses a word length of 5 to 8 bits, parity on or off, even or odd parity, a fixed ("sticky") parity value, and one, one-and-a-half or two stop bits. A further bit forces the line low to send a break. Timing comes from an external enable pulse at 16 times the bit rate, so every bit lasts 16 of those ticks. The format is captured when a character is accepted; the break control acts on the pin at once. The `tx_idle` flag tells software when the line is quiet, which is when the break control should be changed.

Top module: `uart_tx_framer`

## Requirements
- R1: A frame begins with a start bit at level 0, followed by the data bits, least significant first. The word length comes from `lcr_cfg[1:0]`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the word length have no effect on the line. Each bit lasts 16 ticks of `tick16`, and the start bit begins in the cycle after acceptance.
- R2: With `lcr_cfg[3]`=1 and `lcr_cfg[5]`=0, one parity bit follows the data bits. If `lcr_cfg[4]`=1 (even), the data bits plus the parity bit hold an even number of ones. If `lcr_cfg[4]`=0 (odd), they hold an odd number. Only the active data bits are counted.
- R3: With `lcr_cfg[3]`=1 and `lcr_cfg[5]`=1, the parity bit is the inverse of `lcr_cfg[4]`, whatever the data.
- R4: With `lcr_cfg[3]`=0, no parity bit is sent and `lcr_cfg[5]` has no effect. The stop period follows the last data bit directly.
- R5: The stop period is at level 1. With `lcr_cfg[2]`=0 it lasts 16 ticks. With `lcr_cfg[2]`=1 it lasts 24 ticks for a 5-bit word and 32 ticks for 6 to 8 bits. `tx_idle` rises on the edge that consumes the last tick of the stop period.
- R6: While `lcr_cfg[6]`=1, `txd` is 0. The frame sequencer keeps its timing, so bit boundaries and the rise of `tx_idle` do not move.
- R7: While idle, `txd` is 1 unless a break is forced. `tx_idle` is 0 from the cycle after acceptance until the frame ends.
- R8: `in_ready` equals `tx_idle`. A character is taken only on `in_valid && in_ready`. A valid offered during a frame does not change that frame and does not start a new one.
- R9: The format fields `lcr_cfg[5:0]` are captured at acceptance. Changing them during a frame leaves that frame unchanged. `lcr_cfg[7]` has no effect.
- R10: A synchronous reset leaves the framer idle with `txd`=1 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| lcr_cfg | input | 8 | Line-control byte (format, break) |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Framer will take a character |
| txd | output | 1 | Serial transmit line |
| tx_idle | output | 1 | Line idle, no frame in progress |

## Verification
The hardest case to reach is a break or a format change during a frame. Software should not make that change, yet the sequencer must keep its timing and the frame in flight must not change. The stimulus gets there on purpose. In some frames the break bit is raised just after the start bit and cleared before the stop period. In others the format bits are scrambled between the start bit and the stop period. In all such frames the bench samples every bit at its midpoint and checks the exact tick on which `tx_idle` rises. Other frames keep `in_valid` high with different data during the frame, to show that back-pressure holds.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int STOP_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [3:0]        nbits;
    logic              par_en;
    logic              par_bit;
    logic [STOP_W-1:0] stop_ticks;
  } frame_cfg_t;
endpackage

// File: rtl/utx_fmt_decode.sv
module utx_fmt_decode
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic [5:0]        fmt,
  input  logic [DATA_W-1:0] data,
  output frame_cfg_t        cfg
);
  localparam int HALF = OVS / 2;

  logic [DATA_W-1:0] mask;
  logic [3:0]        nbits;
  logic              ones_odd;

  assign nbits = 4'd5 + {2'b00, fmt[1:0]};

  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_mask
      assign mask[g] = (g < int'(nbits));
    end
  endgenerate

  assign ones_odd = ^(data & mask);

  always_comb begin
    cfg.nbits  = nbits;
    cfg.par_en = fmt[3];
    if (fmt[5])
      cfg.par_bit = ~fmt[4];
    else
      cfg.par_bit = fmt[4] ? ones_odd : ~ones_odd;
    if (!fmt[2])
      cfg.stop_ticks = STOP_W'(OVS);
    else if (fmt[1:0] == 2'b00)
      cfg.stop_ticks = STOP_W'(OVS + HALF);
    else
      cfg.stop_ticks = STOP_W'(2 * OVS);
  end
endmodule

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = run && tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run || done)
      cnt <= '0;
    else if (tick)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/utx_seq.sv
module utx_seq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  frame_cfg_t        cfg_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              bit_done,
  output logic              line,
  output logic              idle,
  output logic              run,
  output logic [STOP_W-1:0] limit
);
  tx_state_e         state;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] shreg;
  logic [3:0]        idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cfg_q <= '0;
      shreg <= '0;
      idx   <= '0;
    end else if (state == ST_IDLE) begin
      if (accept) begin
        state <= ST_START;
        cfg_q <= cfg_in;
        shreg <= data_in;
        idx   <= '0;
      end
    end else if (bit_done) begin
      unique case (state)
        ST_START: state <= ST_DATA;
        ST_DATA: begin
          shreg <= shreg >> 1;
          idx   <= idx + 1'b1;
          if (idx == cfg_q.nbits - 1'b1)
            state <= cfg_q.par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR:  state <= ST_STOP;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg[0];
      ST_PAR:   line = cfg_q.par_bit;
      default:  line = 1'b1;
    endcase
  end

  assign idle  = (state == ST_IDLE);
  assign run   = !idle;
  assign limit = (state == ST_STOP) ? cfg_q.stop_ticks : STOP_W'(OVS);
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic [7:0]        lcr_cfg,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              txd,
  output logic              tx_idle
);
  frame_cfg_t        cfg_now;
  logic              accept;
  logic              line;
  logic              run;
  logic              bit_done;
  logic [STOP_W-1:0] limit;
  logic              unused_div_access;

  assign unused_div_access = lcr_cfg[7];

  utx_fmt_decode #(.DATA_W(DATA_W), .OVS(OVS)) i_dec (
    .fmt  (lcr_cfg[5:0]),
    .data (in_data),
    .cfg  (cfg_now)
  );

  utx_bit_timer #(.CNT_W(STOP_W)) i_timer (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .tick  (tick16),
    .limit (limit),
    .done  (bit_done)
  );

  utx_seq #(.DATA_W(DATA_W), .OVS(OVS)) i_seq (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .cfg_in   (cfg_now),
    .data_in  (in_data),
    .bit_done (bit_done),
    .line     (line),
    .idle     (tx_idle),
    .run      (run),
    .limit    (limit)
  );

  assign in_ready = tx_idle;
  assign accept   = in_valid && in_ready;
  assign txd      = lcr_cfg[6] ? 1'b0 : line;
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick16,
  input logic [7:0] lcr_cfg,
  input logic       in_valid,
  input logic       in_ready,
  input logic       txd,
  input logic       tx_idle
);
  assert_break_low_R6: assert property (@(posedge clk) disable iff (rst)
    lcr_cfg[6] |-> !txd);

  assert_idle_mark_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_idle && !lcr_cfg[6]) |-> txd);

  assert_start_low_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (lcr_cfg[6] || !txd));

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !tx_idle);

  assert_stay_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_idle && !in_valid) |=> tx_idle);

  assert_end_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (!tx_idle && !in_valid) |=> (!tx_idle || $past(tick16)));
endmodule

bind uart_tx_framer uart_tx_framer_chk i_chk (.*);

// File: tb/test_uart_tx_framer.sv
module test_uart_tx_framer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic [7:0] lcr_cfg = 8'h00;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       txd;
  logic       tx_idle;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int divcnt = 0;

  uart_tx_framer i_uart_tx_framer (
    .clk(clk), .rst(rst), .tick16(tick16), .lcr_cfg(lcr_cfg),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .txd(txd), .tx_idle(tx_idle)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    divcnt = (divcnt == 2) ? 0 : divcnt + 1;
    tick16 = (divcnt == 2);
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (tick16 !== 1'b1);
    end
    @(negedge clk);
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic [7:0] c);
    int ones = 0;
    for (int i = 0; i < 5 + int'(c[1:0]); i++) ones += d[i];
    if (c[5]) return ~c[4];
    return c[4] ? logic'(ones % 2) : ~logic'(ones % 2);
  endfunction

  function automatic int stop_len(input logic [7:0] c);
    if (!c[2]) return 16;
    return (c[1:0] == 2'b00) ? 24 : 32;
  endfunction

  // mode 0 plain, 1 valid held during frame, 2 format scrambled, 3 break mid-frame
  task automatic run_frame(input logic [7:0] d, input logic [7:0] c, input int mode);
    int nb = 5 + int'(c[1:0]);
    int nbit = 1 + nb + (c[3] ? 1 : 0);
    logic exp;
    string tag;
    @(negedge clk);
    lcr_cfg = c; in_data = d; in_valid = 1'b1;
    chk("R8 ready when idle", in_ready, 1'b1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (mode == 1) begin in_valid = 1'b1; in_data = ~d; end
    chk("R7 busy after accept", tx_idle, 1'b0);
    for (int b = 0; b < nbit; b++) begin
      wait_ticks(8);
      if (b == 0) begin exp = 1'b0; tag = "R1 start"; end
      else if (b <= nb) begin exp = d[b-1]; tag = "R1 data"; end
      else begin exp = par_of(d, c); tag = c[5] ? "R3 sticky" : "R2 parity"; end
      if (mode == 2) tag = {tag, " R9"};
      if (lcr_cfg[6]) tag = {tag, " R6"};
      chk(tag, txd, lcr_cfg[6] ? 1'b0 : exp);
      if (mode == 1) chk("R8 ready low while busy", in_ready, 1'b0);
      if (b == 0 && mode == 2) lcr_cfg = {$urandom_range(1, 0) == 1, c[6], 6'($urandom)};
      if (b == 0 && mode == 3) lcr_cfg[6] = 1'b1;
      wait_ticks(8);
    end
    if (mode == 1) in_valid = 1'b0;
    if (mode == 2 || mode == 3) lcr_cfg = c;
    wait_ticks(8);
    chk(c[3] ? "R5 stop level" : "R4 R5 stop after data", txd, c[6] ? 1'b0 : 1'b1);
    wait_ticks(stop_len(c) - 9);
    chk(mode == 3 ? "R6 R5 busy before stop end" : "R5 busy before stop end", tx_idle, 1'b0);
    wait_ticks(1);
    chk(mode == 3 ? "R6 R5 idle at stop end" : "R5 idle at stop end", tx_idle, 1'b1);
    chk("R7 idle line", txd, c[6] ? 1'b0 : 1'b1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset txd", txd, 1'b1);
    chk("R10 reset idle", tx_idle, 1'b1);
    chk("R10 reset ready", in_ready, 1'b1);

    // directed: each word length, 1 and 2 stop bits
    run_frame(8'hA5, 8'b0000_0000, 0);
    run_frame(8'h3C, 8'b0000_0101, 0);
    run_frame(8'h96, 8'b0000_0110, 0);
    run_frame(8'hD3, 8'b1000_0111, 0);
    // 5-bit word, 1.5 stop, upper bits set (ignored)
    run_frame(8'hE1, 8'b0000_0100, 0);
    // parity even / odd, 5-bit with all ones
    run_frame(8'hFF, 8'b0001_1000, 0);
    run_frame(8'hFF, 8'b0000_1000, 0);
    // sticky parity, both selects; sticky without parity enable
    run_frame(8'h0F, 8'b0011_1011, 0);
    run_frame(8'h0F, 8'b0010_1011, 0);
    run_frame(8'h55, 8'b0011_0011, 0);
    // whole-frame break, then mid-frame break, held valid, scrambled format
    run_frame(8'h81, 8'b0100_1111, 0);
    run_frame(8'h81, 8'b0000_1111, 3);
    run_frame(8'h6A, 8'b0001_1010, 1);
    run_frame(8'h6A, 8'b0001_1110, 2);

    // valid held while reset stays idle
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    chk("R10 idle during reset", tx_idle, 1'b1);
    rst = 1'b0; in_valid = 1'b0; lcr_cfg = 8'h00;
    @(negedge clk);
    chk("R10 txd after reset", txd, 1'b1);

    for (int n = 0; n < 60; n++) begin
      logic [7:0] c = 8'($urandom);
      int mode = int'($urandom_range(3, 0));
      if ($urandom_range(7, 0) != 0) c[6] = 1'b0;
      run_frame(8'($urandom), c, mode);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule